// File: doc/BRIEF.md
# Queue Head Overlay Sequencer

This block handles one queue head of a host controller's transfer schedule. After a start strobe that carries the queue head address, it reads the horizontal link word, the current-descriptor pointer word and the nine-word transfer working area (the overlay) that sits inside the queue head. The working area is stored in a small local RAM. One flag bit in the working area's status word says whether a transfer is active.

If no transfer is active, the block simply reports the next queue head, taken from the horizontal link. If a transfer is active, it hands the transfer to the bus packet engine through a start/complete handshake. The status that the engine returns goes into the working area and not into memory. When the engine reports completion, the block copies the nine working words back to the source descriptor named by the current-descriptor pointer, with the active flag cleared. It then reports the next queue head.

The pointers to the next and alternate descriptors are read as part of the working area and written back unchanged. They are never used as addresses, because this block does not advance the queue. Memory is reached through a word-wide request/acknowledge port that has one request in flight at a time.

Top module: `qh_overlay_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `xfer_start` are low.
- R2: After an accepted start at queue head byte address B (bits 1:0 cleared), the reads go, in order, to B+0 (horizontal link), B+12 (current-descriptor pointer), and then B+16, B+20, and so on up to B+48 (the nine working words, in increasing address order).
- R3: The active flag is bit 7 of working word 2 (byte offset 24 in the queue head). When that bit is 0, no transfer start is given, no memory write is made, and `done` reports the link word with bits 4:0 cleared.
- R4: When the flag is 1, exactly one single-cycle `xfer_start` pulse is given after the last working word is read. The block then waits for `xfer_done`, and the `xfer_status` value present in that cycle replaces working word 2.
- R5: On completion, nine writes go to P+0, P+4, up to P+32 in increasing order, where P is the current-descriptor pointer with bits 4:0 cleared. Their data are the working words as read, except that word 2 is the engine status with bit 7 cleared.
- R6: No memory access is ever made to an address held in working word 0 or word 1 (the next and alternate descriptor pointers).
- R7: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable while a request waits for `mem_ack`. `mem_req` is low in the cycle after an acknowledge. All addresses are word aligned.
- R8: A start strobe that arrives while the block is busy is ignored and does not change the access sequence of the run in progress.
- R9: `done` is a one-cycle pulse, and `next_qh` holds the next queue head address while `done` is high. After `done`, a new start is accepted.
- R10: During a run, no write is made to any word of the queue head itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for one queue head |
| start_addr | input | AW | Queue head byte address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |
| xfer_start | output | 1 | Pulse that starts the packet engine |
| xfer_done | input | 1 | Packet engine finished |
| xfer_status | input | DW | Status word from the packet engine |
| done | output | 1 | One-cycle pulse at the end of a run |
| next_qh | output | AW | Next queue head address |

## Verification
Queue heads are tried with the active flag clear, which must give a read-only pass that ends at the horizontal link, and with the flag set, which must give a transfer followed by write-back. These two cases show that the decision is taken from the right bit. Engine status values that have bit 7 set show whether write-back really clears the flag. Descriptor pointers with nonzero low bits show whether address bits 4:0 are dropped. Next and alternate pointers that aim at watched addresses would expose any access that follows them. A start pulse injected mid-run separates a block that ignores it from one that restarts. Random acknowledge and engine latencies vary all cycle timing, which exposes requests that are not held until they are accepted.

// File: rtl/qho_pkg.sv
package qho_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LINK, S_CUR, S_OVL, S_XFER, S_WB_PRE, S_WB, S_FIN
  } qho_state_t;

  localparam int QH_LINK_OFS = 0;
  localparam int QH_CUR_OFS  = 12;
  localparam int QH_OVL_OFS  = 16;
  localparam int TOK_WORD    = 2;
  localparam int ACT_BIT     = 7;
  localparam int PTR_LSB     = 5;
endpackage

// File: rtl/qho_overlay_ram.sv
module qho_overlay_ram #(
  parameter int DEPTH = 9,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/qho_req_port.sv
module qho_req_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  output logic          accept
);
  assign accept = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (accept) begin
      mem_req <= 1'b0;
    end else if (issue && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= iss_we;
      mem_addr  <= iss_addr;
      mem_wdata <= iss_wdata;
    end
  end

  // R7: request fields held until accepted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R7: gap after each acknowledge
  p_gap_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req);
  // R7: issue only when the port is free
  p_issue_free_r7: assert property (@(posedge clk) disable iff (rst)
    issue |-> !mem_req);
endmodule

// File: rtl/qh_overlay_seq.sv
module qh_overlay_seq #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int OVL_WORDS = 9,
  localparam int IW       = $clog2(OVL_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_start,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_status,
  output logic          done,
  output logic [AW-1:0] next_qh
);
  import qho_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(OVL_WORDS - 1);
  localparam logic [IW-1:0] TOK_IDX  = IW'(TOK_WORD);
  localparam logic [AW-1:0] PTR_MASK = ~AW'((1 << PTR_LSB) - 1);
  localparam logic [AW-1:0] WRD_MASK = ~AW'(3);
  localparam logic [DW-1:0] ACT_MASK = DW'(1) << ACT_BIT;

  qho_state_t    state;
  logic [AW-1:0] base, link, cur;
  logic [IW-1:0] idx;
  logic          sent, tok_act;

  logic          issue, iss_we, accept;
  logic [AW-1:0] iss_addr, wb_base;
  logic [DW-1:0] iss_wdata, rd_q;
  logic          ram_we;
  logic [IW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;

  assign wb_base = cur & PTR_MASK;

  qho_req_port #(.AW(AW), .DW(DW)) i_port (
    .clk(clk), .rst(rst), .issue(issue), .iss_we(iss_we),
    .iss_addr(iss_addr), .iss_wdata(iss_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .accept(accept)
  );

  qho_overlay_ram #(.DEPTH(OVL_WORDS), .DW(DW)) i_ovl (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(idx), .rdata(rd_q)
  );

  always_comb begin
    issue     = 1'b0;
    iss_we    = 1'b0;
    iss_addr  = '0;
    iss_wdata = '0;
    ram_we    = 1'b0;
    ram_waddr = idx;
    ram_wdata = mem_rdata;
    case (state)
      S_LINK: begin
        issue    = !sent;
        iss_addr = base + AW'(QH_LINK_OFS);
      end
      S_CUR: begin
        issue    = !sent;
        iss_addr = base + AW'(QH_CUR_OFS);
      end
      S_OVL: begin
        issue    = !sent;
        iss_addr = base + AW'(QH_OVL_OFS) + (AW'(idx) << 2);
        ram_we   = accept;
      end
      S_XFER: begin
        ram_we    = xfer_done;
        ram_waddr = TOK_IDX;
        ram_wdata = xfer_status;
      end
      S_WB: begin
        issue     = !sent;
        iss_we    = 1'b1;
        iss_addr  = wb_base + (AW'(idx) << 2);
        iss_wdata = (idx == TOK_IDX) ? (rd_q & ~ACT_MASK) : rd_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      base       <= '0;
      link       <= '0;
      cur        <= '0;
      idx        <= '0;
      sent       <= 1'b0;
      tok_act    <= 1'b0;
      xfer_start <= 1'b0;
      done       <= 1'b0;
      next_qh    <= '0;
    end else begin
      done       <= 1'b0;
      xfer_start <= 1'b0;
      if (issue) sent <= 1'b1;
      if (accept) sent <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          base    <= start_addr & WRD_MASK;
          idx     <= '0;
          tok_act <= 1'b0;
          sent    <= 1'b0;
          state   <= S_LINK;
        end
        S_LINK: if (accept) begin
          link  <= mem_rdata;
          state <= S_CUR;
        end
        S_CUR: if (accept) begin
          cur   <= mem_rdata;
          state <= S_OVL;
        end
        S_OVL: if (accept) begin
          if (idx == TOK_IDX) tok_act <= mem_rdata[ACT_BIT];
          if (idx == LAST_IDX) begin
            idx <= '0;
            if (tok_act) begin
              xfer_start <= 1'b1;
              state      <= S_XFER;
            end else begin
              state <= S_FIN;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_XFER: if (xfer_done) state <= S_WB_PRE;
        S_WB_PRE: state <= S_WB;
        S_WB: if (accept) begin
          if (idx == LAST_IDX) begin
            state <= S_FIN;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_WB_PRE;
          end
        end
        S_FIN: begin
          done    <= 1'b1;
          next_qh <= link & PTR_MASK;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: transfer start lasts one cycle and leads to waiting
  p_xfer_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);
  // R3: no write unless the working area held an active transfer
  p_write_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> tok_act);
  // R2: addresses word aligned
  p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R8: start while busy leaves the queue head base unchanged
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    start && state != S_IDLE |=> $stable(base));
endmodule

// File: tb/test_qh_overlay_seq.sv
`timescale 1ns/1ps
module test_qh_overlay_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xfer_start;
  logic        xfer_done = 1'b0;
  logic [31:0] xfer_status;
  logic        done;
  logic [31:0] next_qh;

  logic [31:0] mem [1024];
  logic [31:0] stat_val = '0;
  logic [31:0] fb0 = 32'hFFFF_FFF0, fb1 = 32'hFFFF_FFF0;
  assign xfer_status = stat_val;

  int n_checks = 0, n_fail = 0;
  int rn = 0, wn = 0, forb = 0, pviol = 0, xs_cnt = 0;
  logic [31:0] rlog [1024];
  logic [31:0] wlog_a [1024];
  logic [31:0] wlog_d [1024];
  logic        preq = 1'b0, pack = 1'b0, pwe = 1'b0;
  logic [31:0] paddr = '0, pwd = '0;
  logic        xbusy = 1'b0;
  int          xdly = 0;

  always #4 clk = ~clk;

  qh_overlay_seq i_qh_overlay_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_status(xfer_status),
    .done(done), .next_qh(next_qh)
  );

  // memory responder, protocol monitor and packet engine stub
  always @(negedge clk) begin
    logic na;
    na = 1'b0;
    if (!rst) begin
      if (preq && !pack && (!mem_req || mem_addr != paddr || mem_we != pwe || mem_wdata != pwd))
        pviol <= pviol + 1;
      if (preq && pack && mem_req) pviol <= pviol + 1;
      if (mem_req && !mem_ack && ($urandom_range(0, 2) == 0)) begin
        na = 1'b1;
        if (mem_addr == fb0 || mem_addr == fb1) forb <= forb + 1;
        if (mem_we) begin
          wlog_a[wn] <= mem_addr;
          wlog_d[wn] <= mem_wdata;
          wn <= wn + 1;
        end else begin
          mem_rdata <= mem[mem_addr[11:2]];
          rlog[rn] <= mem_addr;
          rn <= rn + 1;
        end
      end
      xfer_done <= 1'b0;
      if (xfer_start) begin
        xs_cnt <= xs_cnt + 1;
        xbusy  <= 1'b1;
        xdly   <= $urandom_range(0, 5);
      end else if (xbusy) begin
        if (xdly == 0) begin
          xfer_done <= 1'b1;
          xbusy     <= 1'b0;
        end else begin
          xdly <= xdly - 1;
        end
      end
    end
    mem_ack <= na;
    preq  <= mem_req;
    pack  <= na;
    paddr <= mem_addr;
    pwe   <= mem_we;
    pwd   <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wb(input logic [31:0] ov, input int i,
                                         input logic [31:0] st);
    return (i == 2) ? (st & ~32'h80) : ov;
  endfunction

  task automatic run_qh(input int unsigned qh, input int unsigned td, input bit act,
                        input logic [31:0] st, input bit poke);
    logic [31:0] ov [9];
    logic [31:0] qh_img [13];
    logic [31:0] link, cur;
    int r0, w0, f0, x0, t;
    link = {$urandom_range(0, 15) * 64 + $urandom_range(0, 31)} ;
    cur  = td | $urandom_range(0, 31);
    fb0  = 32'h800 + $urandom_range(0, 63) * 8;
    fb1  = 32'hC00 + $urandom_range(0, 63) * 8;
    for (int i = 0; i < 9; i++) ov[i] = $urandom;
    ov[0] = fb0;
    ov[1] = fb1;
    ov[2] = act ? (ov[2] | 32'h80) : (ov[2] & ~32'h80);
    qh_img[0] = link; qh_img[1] = $urandom; qh_img[2] = $urandom; qh_img[3] = cur;
    for (int i = 0; i < 9; i++) qh_img[4+i] = ov[i];
    for (int i = 0; i < 13; i++) mem[qh/4 + i] = qh_img[i];
    stat_val = st;
    r0 = rn; w0 = wn; f0 = forb; x0 = xs_cnt;
    start_addr = qh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start_addr = (qh + 32'h40) & 32'h3FF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R9", "done seen", {31'd0, done}, 32'd1);
    chk(next_qh == (link & ~32'h1F), "R3", "next queue head", next_qh, link & ~32'h1F);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", {31'd0, done}, 32'd0);
    chk(rn - r0 == 11, "R2", "read count", rn - r0, 11);
    if (rn - r0 == 11) begin
      chk(rlog[r0] == qh, "R2", "link read address", rlog[r0], qh);
      chk(rlog[r0+1] == qh + 12, "R2", "pointer read address", rlog[r0+1], qh + 12);
      for (int i = 0; i < 9; i++)
        chk(rlog[r0+2+i] == qh + 16 + 4*i, poke ? "R8" : "R2", "working read address",
            rlog[r0+2+i], qh + 16 + 4*i);
    end
    chk(xs_cnt - x0 == int'(act), "R4", "transfer starts", xs_cnt - x0, act);
    if (!act) begin
      chk(wn == w0, "R3", "no write when inactive", wn - w0, 0);
    end else begin
      chk(wn - w0 == 9, "R5", "write count", wn - w0, 9);
      if (wn - w0 == 9)
        for (int i = 0; i < 9; i++) begin
          chk(wlog_a[w0+i] == td + 4*i, "R5", "write-back address", wlog_a[w0+i], td + 4*i);
          chk(wlog_d[w0+i] == exp_wb(ov[i], i, st), i == 2 ? "R4" : "R5",
              "write-back data", wlog_d[w0+i], exp_wb(ov[i], i, st));
        end
    end
    for (int i = w0; i < wn; i++)
      chk(!(wlog_a[i] >= qh && wlog_a[i] < qh + 52), "R10", "queue head untouched",
          wlog_a[i], td);
    chk(forb == f0, "R6", "chain pointer access", forb - f0, 0);
    chk(pviol == 0, "R7", "request handshake", pviol, 0);
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    chk(1'b0, "R9", "watchdog expired", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_req && !xfer_start, "R1", "reset state",
        {29'd0, done, mem_req, xfer_start}, 32'd0);
    run_qh(32'h000, 32'h400, 1'b0, 32'h0, 1'b0);
    run_qh(32'h040, 32'h440, 1'b1, 32'h1234_5600, 1'b0);
    run_qh(32'h080, 32'h480, 1'b1, 32'hFFFF_FFFF, 1'b0);
    run_qh(32'h0C0, 32'h4C0, 1'b1, 32'h0000_0080, 1'b1);
    run_qh(32'h100, 32'h500, 1'b0, 32'h0, 1'b1);
    for (int k = 0; k < 24; k++)
      run_qh($urandom_range(0, 15) * 64, 32'h400 + $urandom_range(0, 15) * 64,
             1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule